// File: doc/BRIEF.md
# Extended cartridge program-ROM window decoder

This block sits between a console CPU's cartridge bus and a program ROM. It stretches the linearly addressed ROM window from the usual upper half of the CPU space down into the top of the lower half. For the cartridge build (`AW` = 15) the ROM answers from $4800 to $FFFF, which is 47104 bytes. The 2 KiB chunk at $4000-$47FF and everything below $4000 stay silent. Ordinary accesses to the upper half are recognised by the cartridge's active-low ROM strobe. The extra window is recognised by a 3-to-8 decoder stage. That stage is fed by the strobe, the CPU phase-2 clock `m2` and the four address lines below the top line. A parameter picks whether this stage produces positive or inverted outputs.

The ROM address is formed without logic. The CPU address lines go straight through, and the strobe itself becomes the ROM's top address line, with no inverter. The strobe is the inverse of the missing CPU top line, so the stored image must be reordered. The linear image holds three segments (0 = lowest). They go into ROM in the order 1, 2, 0, 0. This means the image's first chunk, one eighth of a segment, can never be read. A behavioural ROM array is included. It has a load port for the bench and a registered read port written so that block RAM can be inferred. Read data appears one clock after a qualified read, together with a drive-enable. The drive-enable is meant to control an external tri-state buffer, and when it is low the bus is released.

Top module: `ext_rom_window`

## Requirements
- R1: While `rom_sel_n` is 0, `rom_ce_n` is 0 whatever the values of `m2`, `cpu_addr` and `cpu_rw`.
- R2: While `rom_sel_n` is 1, `rom_ce_n` is 0 when `m2` is 1, `cpu_addr[AW-1]` is 1 and `cpu_addr[AW-2:AW-4]` is not 000. For `AW` = 15 this is CPU $4800-$7FFF.
- R3: While `rom_sel_n` is 1, `rom_ce_n` stays 1 when `cpu_addr[AW-1]` is 0 or `cpu_addr[AW-2:AW-4]` is 000. For `AW` = 15 this is everything below $4800.
- R4: While `rom_sel_n` is 1 and `m2` is 0, `rom_ce_n` stays 1 for every address.
- R5: `rom_addr` equals `{rom_sel_n, cpu_addr}`: the strobe is the ROM's top line, uninverted.
- R6: `rom_oe` is 1 exactly when `rom_ce_n` is 0 and `cpu_rw` is 1 (1 = read, 0 = write).
- R7: One clock after a cycle with `rom_oe` = 1, `bus_drive` is 1 and `bus_data` holds the byte stored at that cycle's `rom_addr`. After any other cycle, `bus_drive` is 0 and `bus_data` is 0.
- R8: A byte written with `load_en` = 1 is stored at `load_addr`. When the three image segments are loaded in the order 1, 2, 0, 0, a read at full CPU address C (top bit = NOT `rom_sel_n`) returns byte C - 2^(AW-1) of the linear image, for every enabled C.
- R9: Both settings of `DEC_POL` (positive or inverted decoder outputs) give identical port behaviour.
- R10: A synchronous active-high `rst` clears `bus_drive` and `bus_data` at the next clock edge, even during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the ROM read register and load port |
| rst | input | 1 | Synchronous active-high reset |
| rom_sel_n | input | 1 | Active-low cartridge ROM strobe (inverse of CPU top address line) |
| m2 | input | 1 | CPU phase-2 clock, qualifies the extra window |
| cpu_addr | input | AW | CPU address lines below the top line |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| load_en | input | 1 | Bench load strobe for the ROM array |
| load_addr | input | AW+1 | ROM address for a load |
| load_data | input | DW | Byte to load |
| rom_ce_n | output | 1 | Active-low ROM chip enable |
| rom_addr | output | AW+1 | ROM address |
| rom_oe | output | 1 | ROM output enable (enabled read) |
| bus_data | output | DW | Registered read data, 0 when not driving |
| bus_drive | output | 1 | Registered drive-enable for the data bus buffer |

## Verification
The bench builds the block twice at `AW` = 11, once with positive and once with inverted decoder outputs, and drives both with the same stimulus. At this width the ROM is 4 KiB and the CPU space is 4096 bytes. This makes it possible to sweep every address under every combination of strobe, `m2` and read/write. The small width keeps the same proportions as the cartridge build: a 128-byte dead chunk and three 1 KiB segments. So the window edges, the reordered 1, 2, 0, 0 layout and the unreachable first chunk are all checked address by address against values the bench computes arithmetically.

// File: rtl/ext_rom_pkg.sv
package ext_rom_pkg;

  // Output polarity of the 3-to-8 decode stage.
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } dec_pol_e;

  // Level of the read/write line that means "read".
  localparam logic RW_READ = 1'b1;

endpackage

// File: rtl/en_decoder_3to8.sv
module en_decoder_3to8
  import ext_rom_pkg::*;
#(
  parameter dec_pol_e POL = POL_HIGH
) (
  input  logic       g1_n,
  input  logic       g2_n,
  input  logic       g3,
  input  logic [2:0] sel,
  output logic [7:0] y
);

  logic       active;
  logic [7:0] onehot;

  // All three gates must be open before any line is selected.
  always_comb begin
    active = ~g1_n & ~g2_n & g3;
    onehot = '0;
    if (active) onehot[sel] = 1'b1;
  end

  generate
    if (POL == POL_HIGH) begin : g_pos
      assign y = onehot;
    end else begin : g_neg
      assign y = ~onehot;
    end
  endgenerate

endmodule

// File: rtl/rom_window_decode.sv
module rom_window_decode
  import ext_rom_pkg::*;
#(
  parameter int       AW  = 11,
  parameter dec_pol_e POL = POL_HIGH
) (
  input  logic          rom_sel_n,
  input  logic          m2,
  input  logic [AW-1:0] cpu_addr,
  output logic          ce_n,
  output logic          win_hit,
  output logic [AW:0]   mem_addr
);

  // The decoder selects on the three lines just below the top line.
  localparam int SEL_TOP = AW - 2;

  logic [7:0] dec_y;

  // Gate 1: strobe idle (CPU in lower half). Gate 2: top line set.
  // Gate 3: phase-2 high.
  en_decoder_3to8 #(.POL(POL)) u_dec (
    .g1_n (~rom_sel_n),
    .g2_n (~cpu_addr[AW-1]),
    .g3   (m2),
    .sel  (cpu_addr[SEL_TOP -: 3]),
    .y    (dec_y)
  );

  // Lines 1..7 open the window; line 0 is the dead chunk.
  generate
    if (POL == POL_HIGH) begin : g_or_pos
      assign win_hit = |dec_y[7:1];
    end else begin : g_or_neg
      assign win_hit = ~&dec_y[7:1];
    end
  endgenerate

  assign ce_n     = ~(~rom_sel_n | win_hit);
  assign mem_addr = {rom_sel_n, cpu_addr};

endmodule

// File: rtl/rom_array.sv
module rom_array #(
  parameter int MAW = 12,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [MAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [MAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid
);

  localparam int DEPTH = 1 << MAW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;
  logic          valid_q;

  // Plain write/read ports with no reset on the array or read register.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_en;
  end

  assign rd_valid = valid_q;
  assign rd_data  = valid_q ? q : '0;

endmodule

// File: rtl/ext_rom_window.sv
module ext_rom_window
  import ext_rom_pkg::*;
#(
  parameter int       AW      = 11,
  parameter int       DW      = 8,
  parameter dec_pol_e DEC_POL = POL_HIGH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rom_sel_n,
  input  logic          m2,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic          load_en,
  input  logic [AW:0]   load_addr,
  input  logic [DW-1:0] load_data,
  output logic          rom_ce_n,
  output logic [AW:0]   rom_addr,
  output logic          rom_oe,
  output logic [DW-1:0] bus_data,
  output logic          bus_drive
);

  localparam int MAW = AW + 1;

  logic win_hit;

  rom_window_decode #(.AW(AW), .POL(DEC_POL)) u_decode (
    .rom_sel_n (rom_sel_n),
    .m2        (m2),
    .cpu_addr  (cpu_addr),
    .ce_n      (rom_ce_n),
    .win_hit   (win_hit),
    .mem_addr  (rom_addr)
  );

  assign rom_oe = ~rom_ce_n & (cpu_rw == RW_READ);

  rom_array #(.MAW(MAW), .DW(DW)) u_rom (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (load_en),
    .wr_addr  (load_addr),
    .wr_data  (load_data),
    .rd_en    (rom_oe),
    .rd_addr  (rom_addr),
    .rd_data  (bus_data),
    .rd_valid (bus_drive)
  );

endmodule

// File: rtl/ext_rom_window_chk.sv
module ext_rom_window_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rom_sel_n,
  input logic          m2,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rw,
  input logic          rom_ce_n,
  input logic          rom_oe,
  input logic [DW-1:0] bus_data,
  input logic          bus_drive
);

  logic chunk_zero;
  assign chunk_zero = (cpu_addr[AW-2 -: 3] == 3'b000);

  AST_STROBE_ENABLES: assert property (@(posedge clk) disable iff (rst)
    !rom_sel_n |-> !rom_ce_n); // R1
  AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (rst)
    (rom_sel_n && m2 && cpu_addr[AW-1] && !chunk_zero) |-> !rom_ce_n); // R2
  AST_GAP_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (rom_sel_n && (!cpu_addr[AW-1] || chunk_zero)) |-> rom_ce_n); // R3
  AST_M2_GATES: assert property (@(posedge clk) disable iff (rst)
    (rom_sel_n && !m2) |-> rom_ce_n); // R4
  AST_OE_READ: assert property (@(posedge clk) disable iff (rst)
    rom_oe |-> (!rom_ce_n && cpu_rw)); // R6
  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> $past(rom_oe)); // R7
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rom_oe)) |-> bus_drive); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> (bus_data == '0)); // R7

endmodule

bind ext_rom_window ext_rom_window_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rom_sel_n (rom_sel_n),
  .m2        (m2),
  .cpu_addr  (cpu_addr),
  .cpu_rw    (cpu_rw),
  .rom_ce_n  (rom_ce_n),
  .rom_oe    (rom_oe),
  .bus_data  (bus_data),
  .bus_drive (bus_drive)
);

// File: tb/ext_rom_window_test.sv
module ext_rom_window_test;
  import ext_rom_pkg::*;

  localparam int AW   = 11;
  localparam int DW   = 8;
  localparam int SPAN = 1 << (AW + 1);  // full CPU space
  localparam int SEG  = 1 << (AW - 1);  // one image segment
  localparam int CHK  = 1 << (AW - 4);  // dead chunk size

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rom_sel_n = 1'b1;
  logic          m2 = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rw = 1'b1;
  logic          load_en = 1'b0;
  logic [AW:0]   load_addr = '0;
  logic [DW-1:0] load_data = '0;

  logic          ce_p, oe_p, drv_p, ce_i, oe_i, drv_i;
  logic [AW:0]   addr_p, addr_i;
  logic [DW-1:0] dat_p, dat_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ext_rom_window #(.AW(AW), .DW(DW), .DEC_POL(POL_HIGH)) uut (
    .clk(clk), .rst(rst), .rom_sel_n(rom_sel_n), .m2(m2), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .rom_ce_n(ce_p), .rom_addr(addr_p), .rom_oe(oe_p), .bus_data(dat_p), .bus_drive(drv_p)
  );

  // R9: inverted-output decoder variant, same stimulus
  ext_rom_window #(.AW(AW), .DW(DW), .DEC_POL(POL_LOW)) uut_inv (
    .clk(clk), .rst(rst), .rom_sel_n(rom_sel_n), .m2(m2), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .rom_ce_n(ce_i), .rom_addr(addr_i), .rom_oe(oe_i), .bus_data(dat_i), .bus_drive(drv_i)
  );

  // Linear image byte; segment index folded in so segments differ.
  function automatic logic [7:0] img_byte(input int i);
    int v;
    v = (i * 13) ^ (i >> 5) ^ ((i / SEG) * 8'h55) ^ 8'h3C;
    return v[7:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (sel_n=%0b m2=%0b a=%0h rw=%0b)",
               req, act, exp, rom_sel_n, m2, cpu_addr, cpu_rw);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    string tag;
    int    cpu;
    bit    exp_ce, exp_oe;
    int    exp_d;

    repeat (3) @(posedge clk);
    #1;
    check("R10 reset drive", drv_p, 0);
    check("R10 reset data", dat_p, 0);
    check("R10 R9 reset drive inv", drv_i, 0);

    // Load ROM in segment order 1,2,0,0 (R8).
    for (int r = 0; r < SPAN; r++) begin
      @(negedge clk);
      rst       = 1'b0;
      load_en   = 1'b1;
      load_addr = r[AW:0];
      load_data = img_byte(r < SPAN / 2 ? r + SEG : r % SEG);
    end
    @(negedge clk);
    load_en = 1'b0;

    // Exhaustive sweep over strobe, m2, rw and every address.
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int w = 0; w < 2; w++) begin
          for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            rom_sel_n = s[0];
            m2        = m[0];
            cpu_rw    = w[0];
            cpu_addr  = a[AW-1:0];
            cpu       = ((s == 0) ? (SPAN / 2) : 0) + a;
            if (s == 0) begin
              exp_ce = 1; tag = "R1";
            end else if (m == 0) begin
              exp_ce = 0; tag = "R4";
            end else if (a >= SEG * 2 / 2 + 0 && a >= (1 << (AW - 1)) + CHK) begin
              exp_ce = 1; tag = "R2";
            end else begin
              exp_ce = 0; tag = "R3";
            end
            exp_oe = exp_ce && (w == 1);
            exp_d  = exp_oe ? int'(img_byte(cpu - SEG)) : 0;
            #1;
            check({tag, " ce_n"}, ce_p, !exp_ce);
            check({tag, " R9 ce_n inv"}, ce_i, !exp_ce);
            check("R5 rom_addr", addr_p, (s << AW) | a);
            check("R5 R9 rom_addr inv", addr_i, (s << AW) | a);
            check("R6 rom_oe", oe_p, exp_oe);
            check("R6 R9 rom_oe inv", oe_i, exp_oe);
            @(posedge clk);
            #1;
            check("R7 bus_drive", drv_p, exp_oe);
            check("R8 R7 bus_data", dat_p, exp_d);
            check("R9 bus_drive inv", drv_i, exp_oe);
            check("R9 R8 bus_data inv", dat_i, exp_d);
          end
        end
      end
    end

    // R10: reset wins over a read in the same cycle.
    @(negedge clk);
    rom_sel_n = 1'b0; m2 = 1'b1; cpu_rw = 1'b1; cpu_addr = 11'h005;
    @(posedge clk);
    #1;
    check("R7 pre-reset drive", drv_p, 1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R10 drive cleared", drv_p, 0);
    check("R10 data cleared", dat_p, 0);
    check("R10 R9 drive cleared inv", drv_i, 0);
    @(negedge clk);
    rst = 1'b0;
    rom_sel_n = 1'b1; m2 = 1'b0;
    @(posedge clk);
    #1;
    check("R7 idle after reset", drv_p, 0);

    summary();
  end

endmodule